// File: doc/BRIEF.md
# Pointer Sprite Overlay

This block lays a 16×16 two-plane hardware pointer over a stream of 4-bit RGBI pixels. On every clock it is given the beam position of the current pixel in 320×200 units, the colour of that pixel, two flat 256-bit bitmaps (a clearing plane and a toggling plane), the pointer position, three enable bits, an 8-bit colour register and a blink phase. It returns the pixel, possibly changed, one clock later.

The pointer position lives on a 512×256 grid. The visible picture starts 16 units in on each axis, so a pointer near the origin can sit wholly outside the picture. Where the pointer covers a pixel, the clearing plane first forces some RGBI lines low. The low nibble of the colour register chooses which lines are spared. The toggling plane then inverts the lines that the high nibble chooses. The block has no state machine. Its only state is the output pixel register.

Top module: `ptr_overlay`

## Requirements
- R1: While rst_n is low, pix_out is 0.
- R2: A pixel the pointer does not draw on appears unchanged on pix_out exactly one clock after it is presented.
- R3: The pointer covers beam (bx,by) when 0 ≤ bx+16−pos_x < 16 and 0 ≤ by+16−pos_y < 16, with no wrap-around. With pos (16,16) it covers beam 0..15 on both axes. With pos (335,215) it covers beam x 319..334 and beam y 199..214.
- R4: With pos_x = 0 and pos_y = 0 the pointer changes no pixel.
- R5: Bitmap byte k occupies bits [8k+7:8k] of each map. Pointer line r uses byte 2r for columns 0..7 and byte 2r+1 for columns 8..15. Column 0 is bit 7 of the even byte and column 15 is bit 0 of the odd byte.
- R6: On a drawn pixel whose clearing bit is 0 and with en_and set, every RGBI line whose bit in color[3:0] is 0 is forced to 0. Bit 0 is blue, bit 1 green, bit 2 red and bit 3 intensity, the same for pix_in, pix_out and color.
- R7: On a drawn pixel whose toggling bit is 1 and with en_xor set, every RGBI line whose bit in color[7:4] is 1 is inverted.
- R8: With en_and low the clearing plane has no effect. With en_xor low the toggling plane has no effect.
- R9: With en_blink set, the pointer is drawn only while blink_on is 1. With en_blink clear, blink_on has no effect.
- R10: On one pixel the clearing step is applied before the toggling step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| beam_x | input | 9 | Beam column in 320-wide units |
| beam_y | input | 8 | Beam line in 200-high units |
| pix_in | input | 4 | Incoming RGBI pixel |
| and_map | input | 256 | Clearing bitmap, 32 bytes |
| xor_map | input | 256 | Toggling bitmap, 32 bytes |
| pos_x | input | 9 | Pointer X on the 512-wide grid |
| pos_y | input | 8 | Pointer Y on the 256-high grid |
| en_blink | input | 1 | Gate the pointer with blink_on |
| en_and | input | 1 | Enable the clearing plane |
| en_xor | input | 1 | Enable the toggling plane |
| color | input | 8 | Low nibble: lines spared by clearing; high nibble: lines toggled |
| blink_on | input | 1 | Blink phase, 1 = on |
| pix_out | output | 4 | Resulting RGBI pixel, one clock late |

## Verification
The only stored state is the output pixel register. A fault in the hit window, the bit index or the combining therefore shows at pix_out in the very next clock. A bad window moves or clips the pointer image at its edge pixels. A bad bit index mirrors it or shifts it by rows. Swapping the two stages turns a clear-then-toggle pixel into all zeros. The bench places single-bit bitmap patterns at the corners of the window and reads each pixel one clock after it is driven.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
    localparam int PTR_SIZE = 16;
    localparam int PTR_ORG  = 16;
    localparam int PIX_W    = 4;
    localparam int POS_XW   = 9;
    localparam int POS_YW   = 8;

    typedef logic [PIX_W-1:0] rgbi_t;
endpackage

// File: rtl/ptr_hit.sv
module ptr_hit #(
    parameter int XW   = 9,
    parameter int YW   = 8,
    parameter int SIZE = 16,
    parameter int ORG  = 16,
    localparam int CW  = $clog2(SIZE)
) (
    input  logic [XW-1:0] beam_x,
    input  logic [YW-1:0] beam_y,
    input  logic [XW-1:0] pos_x,
    input  logic [YW-1:0] pos_y,
    output logic          hit,
    output logic [CW-1:0] row,
    output logic [CW-1:0] col
);
    logic [XW:0] sx, dx;
    logic [YW:0] sy, dy;
    logic        in_x, in_y;

    always_comb begin
        sx   = {1'b0, beam_x} + (XW+1)'(ORG);
        sy   = {1'b0, beam_y} + (YW+1)'(ORG);
        dx   = sx - {1'b0, pos_x};
        dy   = sy - {1'b0, pos_y};
        in_x = (sx >= {1'b0, pos_x}) && (dx < (XW+1)'(SIZE));
        in_y = (sy >= {1'b0, pos_y}) && (dy < (YW+1)'(SIZE));
        hit  = in_x && in_y;
        col  = dx[CW-1:0];
        row  = dy[CW-1:0];
    end
endmodule

// File: rtl/ptr_bitsel.sv
module ptr_bitsel #(
    parameter int SIZE = 16,
    localparam int CW  = $clog2(SIZE),
    localparam int MW  = SIZE * SIZE
) (
    input  logic [MW-1:0] map,
    input  logic [CW-1:0] row,
    input  logic [CW-1:0] col,
    output logic          bit_o
);
    // Line r holds SIZE/8 bytes; within a byte, column order runs from bit 7 down.
    logic [2*CW-1:0] idx;

    always_comb begin
        idx   = {row, col[CW-1:3], ~col[2:0]};
        bit_o = map[idx];
    end
endmodule

// File: rtl/ptr_combine.sv
module ptr_combine
    import ptr_pkg::*;
(
    input  rgbi_t       pix_in,
    input  logic        draw,
    input  logic        en_and,
    input  logic        en_xor,
    input  logic        and_bit,
    input  logic        xor_bit,
    input  logic [7:0]  color,
    output rgbi_t       pix_o
);
    rgbi_t after_and;

    always_comb begin
        after_and = pix_in;
        if (draw && en_and && !and_bit)
            after_and = pix_in & color[3:0];
        pix_o = after_and;
        if (draw && en_xor && xor_bit)
            pix_o = after_and ^ color[7:4];
    end
endmodule

// File: rtl/ptr_overlay.sv
module ptr_overlay
    import ptr_pkg::*;
#(
    parameter int SIZE = PTR_SIZE,
    parameter int ORG  = PTR_ORG,
    localparam int CW  = $clog2(SIZE),
    localparam int MW  = SIZE * SIZE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [POS_XW-1:0] beam_x,
    input  logic [POS_YW-1:0] beam_y,
    input  logic [PIX_W-1:0]  pix_in,
    input  logic [MW-1:0]     and_map,
    input  logic [MW-1:0]     xor_map,
    input  logic [POS_XW-1:0] pos_x,
    input  logic [POS_YW-1:0] pos_y,
    input  logic              en_blink,
    input  logic              en_and,
    input  logic              en_xor,
    input  logic [7:0]        color,
    input  logic              blink_on,
    output logic [PIX_W-1:0]  pix_out
);
    logic          hit, draw, and_bit, xor_bit;
    logic [CW-1:0] row, col;
    rgbi_t         pix_next;

    ptr_hit #(.XW(POS_XW), .YW(POS_YW), .SIZE(SIZE), .ORG(ORG)) u_hit (
        .beam_x(beam_x), .beam_y(beam_y), .pos_x(pos_x), .pos_y(pos_y),
        .hit(hit), .row(row), .col(col)
    );

    ptr_bitsel #(.SIZE(SIZE)) u_and_sel (
        .map(and_map), .row(row), .col(col), .bit_o(and_bit)
    );

    ptr_bitsel #(.SIZE(SIZE)) u_xor_sel (
        .map(xor_map), .row(row), .col(col), .bit_o(xor_bit)
    );

    always_comb draw = hit && (!en_blink || blink_on);

    ptr_combine u_comb (
        .pix_in(pix_in), .draw(draw), .en_and(en_and), .en_xor(en_xor),
        .and_bit(and_bit), .xor_bit(xor_bit), .color(color), .pix_o(pix_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) pix_out <= '0;
        else        pix_out <= pix_next;
    end

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> pix_out == '0);

    assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> pix_out == $past(pix_in));

    assert_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_x == '0 && pos_y == '0) |-> !hit);

    assert_and_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && en_and && !en_xor && !en_blink && !and_bit)
        |=> pix_out == ($past(pix_in) & $past(color[3:0])));

    assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_and && !en_xor) |=> pix_out == $past(pix_in));

    assert_blink_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_blink && !blink_on) |=> pix_out == $past(pix_in));
endmodule

// File: tb/test_ptr_overlay.sv
module test_ptr_overlay;
    localparam int CLK_PERIOD = 10;

    logic         clk = 0;
    logic         rst_n = 0;
    logic [8:0]   beam_x = 0;
    logic [7:0]   beam_y = 0;
    logic [3:0]   pix_in = 0;
    logic [255:0] and_map = '1;
    logic [255:0] xor_map = '0;
    logic [8:0]   pos_x = 0;
    logic [7:0]   pos_y = 0;
    logic         en_blink = 0, en_and = 0, en_xor = 0, blink_on = 0;
    logic [7:0]   color = 8'hF0;
    logic [3:0]   pix_out;

    int checks = 0, bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptr_overlay i_ptr_overlay (
        .clk(clk), .rst_n(rst_n), .beam_x(beam_x), .beam_y(beam_y),
        .pix_in(pix_in), .and_map(and_map), .xor_map(xor_map),
        .pos_x(pos_x), .pos_y(pos_y), .en_blink(en_blink), .en_and(en_and),
        .en_xor(en_xor), .color(color), .blink_on(blink_on), .pix_out(pix_out)
    );

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: pix_out=%h expected=%h", req, got, exp);
        end
    endtask

    // Drive a pixel at a falling edge, read the result at the next falling edge.
    task automatic pixel(input int bx, input int by, input logic [3:0] p,
                         input string req, input logic [3:0] exp);
        beam_x = 9'(bx); beam_y = 8'(by); pix_in = p;
        @(negedge clk);
        check(req, pix_out, exp);
    endtask

    task automatic t_reset;
        pix_in = 4'hF;
        @(negedge clk); @(negedge clk);
        check("R1", pix_out, 4'h0);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic t_pass;
        pos_x = 9'd100; pos_y = 8'd100;
        en_and = 1; and_map = '0; color = 8'h00;
        pixel(0, 0, 4'hA, "R2", 4'hA);
        pixel(200, 150, 4'h3, "R2", 4'h3);
        pixel(319, 199, 4'hC, "R2", 4'hC);
    endtask

    task automatic t_origin;
        pos_x = 0; pos_y = 0; en_and = 1; en_xor = 1;
        and_map = '0; xor_map = '1; color = 8'hF0;
        pixel(0, 0, 4'h9, "R4", 4'h9);
        pixel(15, 15, 4'h6, "R4", 4'h6);
        en_xor = 0; xor_map = '0;
    endtask

    task automatic t_window;
        en_and = 1; and_map = '0; color = 8'h00;
        pos_x = 9'd16; pos_y = 8'd16;
        pixel(0, 0, 4'hF, "R3", 4'h0);
        pixel(15, 15, 4'hF, "R3", 4'h0);
        pixel(16, 0, 4'hF, "R3", 4'hF);
        pixel(0, 16, 4'hF, "R3", 4'hF);
        pos_x = 9'd335; pos_y = 8'd215;
        pixel(319, 199, 4'hF, "R3", 4'h0);
        pixel(318, 199, 4'hF, "R3", 4'hF);
        pixel(319, 198, 4'hF, "R3", 4'hF);
        pixel(334, 214, 4'hF, "R3", 4'h0);
    endtask

    task automatic t_order;
        en_and = 1; color = 8'h00; pos_x = 9'd16; pos_y = 8'd16;
        and_map = '1;
        and_map[8*0 +: 8]  = 8'h7F;
        and_map[8*1 +: 8]  = 8'hFE;
        and_map[8*10 +: 8] = 8'hBF;
        pixel(0, 0, 4'hF, "R5", 4'h0);
        pixel(1, 0, 4'hF, "R5", 4'hF);
        pixel(15, 0, 4'hF, "R5", 4'h0);
        pixel(14, 0, 4'hF, "R5", 4'hF);
        pixel(1, 5, 4'hF, "R5", 4'h0);
        pixel(1, 4, 4'hF, "R5", 4'hF);
    endtask

    task automatic t_and;
        en_and = 1; and_map = '0; pos_x = 9'd16; pos_y = 8'd16;
        color = 8'h05;
        pixel(3, 3, 4'hF, "R6", 4'h5);
        color = 8'h08;
        pixel(3, 3, 4'hE, "R6", 4'h8);
    endtask

    task automatic t_xor;
        en_and = 1; and_map = '1; en_xor = 1; xor_map = '0;
        xor_map[8*4 +: 8] = 8'h10;
        color = 8'hA0;
        pixel(3, 2, 4'h3, "R7", 4'h9);
        pixel(4, 2, 4'h3, "R7", 4'h3);
    endtask

    task automatic t_enables;
        and_map = '0; xor_map = '1; color = 8'hF0;
        en_and = 0; en_xor = 1;
        pixel(5, 5, 4'h6, "R8", 4'h9);
        en_and = 1; en_xor = 0;
        pixel(5, 5, 4'h6, "R8", 4'h0);
        en_and = 0; en_xor = 0;
        pixel(5, 5, 4'h6, "R8", 4'h6);
    endtask

    task automatic t_blink;
        en_and = 1; en_xor = 0; and_map = '0; color = 8'h00;
        en_blink = 1; blink_on = 0;
        pixel(7, 7, 4'hB, "R9", 4'hB);
        blink_on = 1;
        pixel(7, 7, 4'hB, "R9", 4'h0);
        en_blink = 0; blink_on = 0;
        pixel(7, 7, 4'hB, "R9", 4'h0);
    endtask

    task automatic t_stage_order;
        en_and = 1; en_xor = 1; and_map = '0; xor_map = '1; color = 8'hF0;
        pixel(9, 9, 4'h6, "R10", 4'hF);
        color = 8'h31;
        pixel(9, 9, 4'h6, "R10", 4'h3);
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        t_reset;
        t_pass;
        t_origin;
        t_window;
        t_order;
        t_and;
        t_xor;
        t_enables;
        t_blink;
        t_stage_order;
        done = 1;
        finish_run;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++; bad++;
            $display("FAIL watchdog: run hung, got=timeout expected=finish");
            finish_run;
        end
    end
endmodule